// File: doc/BRIEF.md
# Multi-Channel Level Interrupt Multiplexer

The block takes one shared bundle of active-high, level-sensitive interrupt lines and fans it out to a set of independent channels. Every channel sees every source line. Each channel applies its own enable mask to the lines and raises a single combined request when any enabled line is high. The combined request is registered. Software watches that request in one interrupt controller input per channel.

A small register port lets software program each channel's mask and read the live, masked source levels of each channel. The port has a word address, a write strobe and write data, and it returns read data in the same cycle. Nothing in the block latches an event. A pending bit is high exactly while its source line and its mask bit are both high, so software clears a request at the source, or by masking the line. Each channel's two registers sit in a fixed 0x40-byte window, so the code that handles a channel finds them from the channel index alone.

Top module: `irqmux_top`

## Requirements
- R1: After reset every channel mask reads 0x00000000 and every bit of `irq_out` is low.
- R2: The mask of channel n is at byte address 0x10 + 0x40*n. A write stores all 32 bits, and a read returns the last value written. Bit k enables source k for that channel only.
- R3: The pending register of channel n is at byte address 0x20 + 0x40*n. It reads `src_lvl & mask(n)` combinationally, in the same cycle as the source change, and no bit is latched.
- R4: Writes to a pending register are ignored: no mask changes, and the pending value read back stays the same.
- R5: `irq_out[n]` goes high at the first rising clock edge at which some bit of `src_lvl & mask(n)` is set, and it goes low at the first edge at which none is set. It therefore lags a source or mask change by one clock.
- R6: A write to one channel's mask leaves the masks of all other channels unchanged.
- R7: Writing zero to a channel's mask forces that channel's output low from the next edge onward, whatever the sources do.
- R8: Reads of unmapped addresses return zero, and writes to them change no mask. Unmapped addresses are offsets other than 0x10 and 0x20 within a window, addresses whose low two bits are not zero, and windows beyond the last channel.
- R9: All channels observe the same source lines. One source pattern produces in each channel the pending value set by that channel's own mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_lvl | input | NUM_SRC (32) | Level-sensitive, active-high interrupt sources shared by all channels |
| reg_addr | input | ADDR_W (12) | Byte address of the register access |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | NUM_SRC (32) | Write data |
| reg_rdata | output | NUM_SRC (32) | Read data for `reg_addr`, valid in the same cycle |
| irq_out | output | NUM_CH (8) | Registered combined request, one bit per channel |

## Verification
The case that is hardest to reach from the ports is a channel whose mask overlaps the active sources while its neighbours' masks do not. Only then does a wrong channel decode show up as a wrong output bit, and not as a value that is merely unchanged. The stimulus table gives each channel its own mask and source pattern. Between rows it clears the mask so that exactly one output may rise. Directed tests then load two neighbouring channels with different masks, rewrite only one of them, and read both back. A final test drives all sources high and confirms that each channel reports only its own mask.

// File: rtl/irqmux_pkg.sv
package irqmux_pkg;

  // Kind of register selected by an address
  typedef enum logic [1:0] {
    REG_NONE    = 2'd0,
    REG_MASK    = 2'd1,
    REG_PENDING = 2'd2
  } reg_kind_e;

  localparam int unsigned DEF_NUM_SRC     = 32;
  localparam int unsigned DEF_NUM_CH      = 8;
  localparam int unsigned DEF_ADDR_W      = 12;
  localparam int unsigned DEF_STRIDE_LOG2 = 6;     // 0x40-byte window per channel
  localparam int unsigned DEF_MASK_OFS    = 'h10;
  localparam int unsigned DEF_PEND_OFS    = 'h20;

endpackage

// File: rtl/irqmux_regdec.sv
module irqmux_regdec
  import irqmux_pkg::*;
#(
  parameter int unsigned NUM_CH      = DEF_NUM_CH,
  parameter int unsigned ADDR_W      = DEF_ADDR_W,
  parameter int unsigned STRIDE_LOG2 = DEF_STRIDE_LOG2,
  parameter int unsigned MASK_OFS    = DEF_MASK_OFS,
  parameter int unsigned PEND_OFS    = DEF_PEND_OFS,
  localparam int unsigned CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output reg_kind_e         kind,
  output logic [CH_W-1:0]   ch_idx,
  output logic [NUM_CH-1:0] mask_wr
);

  localparam int unsigned WIN_W = ADDR_W - STRIDE_LOG2;
  localparam logic [STRIDE_LOG2-1:0] MASK_LANE = STRIDE_LOG2'(MASK_OFS);
  localparam logic [STRIDE_LOG2-1:0] PEND_LANE = STRIDE_LOG2'(PEND_OFS);

  logic [STRIDE_LOG2-1:0] lane;
  logic [WIN_W-1:0]       win;
  logic                   in_range;

  assign lane     = addr[STRIDE_LOG2-1:0];
  assign win      = addr[ADDR_W-1:STRIDE_LOG2];
  assign in_range = (win < WIN_W'(NUM_CH));
  assign ch_idx   = win[CH_W-1:0];

  // The whole lane, low two bits included, must match: misaligned = unmapped
  always_comb begin
    kind = REG_NONE;
    if (in_range) begin
      if (lane == MASK_LANE)      kind = REG_MASK;
      else if (lane == PEND_LANE) kind = REG_PENDING;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_wsel
    assign mask_wr[g] = wr && (kind == REG_MASK) && (win == WIN_W'(g));
  end

  // R6: at most one channel mask is written per cycle
  assert_single_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mask_wr));

  // R4: a write to a pending register selects no mask
  assert_pend_no_wsel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == REG_PENDING) |-> (mask_wr == '0));

endmodule

// File: rtl/irqmux_channel.sv
module irqmux_channel #(
  parameter int unsigned NUM_SRC = irqmux_pkg::DEF_NUM_SRC
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src,
  input  logic               mask_we,
  input  logic [NUM_SRC-1:0] wdata,
  output logic [NUM_SRC-1:0] mask_q,
  output logic [NUM_SRC-1:0] pend,
  output logic               irq_q
);

  // Full-width mask: a save/restore round-trips every bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= wdata;
  end

  // Live masked levels, nothing latched
  assign pend = src & mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |pend;
  end

  // R2: a write lands in full on the next edge
  assert_mask_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask_q == $past(wdata)));

  // R6: without a write to this channel the mask holds
  assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> $stable(mask_q));

  // R7: an all-zero mask silences the output from the next edge
  assert_zero_mask_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |=> !irq_q);

  // R5: output rises one clock after an enabled source is seen
  assert_irq_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (src & mask_q) != '0 |=> irq_q);

  // R5: output falls one clock after no enabled source remains
  assert_irq_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (src & mask_q) == '0 |=> !irq_q);

endmodule

// File: rtl/irqmux_rdmux.sv
module irqmux_rdmux
  import irqmux_pkg::*;
#(
  parameter int unsigned NUM_CH  = DEF_NUM_CH,
  parameter int unsigned NUM_SRC = DEF_NUM_SRC,
  localparam int unsigned CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  reg_kind_e                       kind,
  input  logic [CH_W-1:0]                 ch_idx,
  input  logic [NUM_CH-1:0][NUM_SRC-1:0]  mask_all,
  input  logic [NUM_CH-1:0][NUM_SRC-1:0]  pend_all,
  output logic [NUM_SRC-1:0]              rdata
);

  logic idx_ok;
  assign idx_ok = (32'(ch_idx) < NUM_CH);

  always_comb begin
    rdata = '0;
    if (idx_ok) begin
      unique case (kind)
        REG_MASK:    rdata = mask_all[ch_idx];
        REG_PENDING: rdata = pend_all[ch_idx];
        default:     rdata = '0;
      endcase
    end
  end

  // R8: unmapped reads return zero
  assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == REG_NONE) |-> (rdata == '0));

  // R3: pending read never shows a bit its mask lacks
  assert_pend_subset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == REG_PENDING && idx_ok) |-> ((rdata & ~mask_all[ch_idx]) == '0));

endmodule

// File: rtl/irqmux_top.sv
module irqmux_top
  import irqmux_pkg::*;
#(
  parameter int unsigned NUM_SRC     = DEF_NUM_SRC,
  parameter int unsigned NUM_CH      = DEF_NUM_CH,
  parameter int unsigned ADDR_W      = DEF_ADDR_W,
  parameter int unsigned STRIDE_LOG2 = DEF_STRIDE_LOG2,
  parameter int unsigned MASK_OFS    = DEF_MASK_OFS,
  parameter int unsigned PEND_OFS    = DEF_PEND_OFS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_lvl,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic [NUM_SRC-1:0] reg_wdata,
  output logic [NUM_SRC-1:0] reg_rdata,
  output logic [NUM_CH-1:0]  irq_out
);

  localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  reg_kind_e                      kind;
  logic [CH_W-1:0]                ch_idx;
  logic [NUM_CH-1:0]              mask_wr;
  logic [NUM_CH-1:0][NUM_SRC-1:0] mask_all;
  logic [NUM_CH-1:0][NUM_SRC-1:0] pend_all;

  irqmux_regdec #(
    .NUM_CH      (NUM_CH),
    .ADDR_W      (ADDR_W),
    .STRIDE_LOG2 (STRIDE_LOG2),
    .MASK_OFS    (MASK_OFS),
    .PEND_OFS    (PEND_OFS)
  ) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (reg_addr),
    .wr      (reg_wr),
    .kind    (kind),
    .ch_idx  (ch_idx),
    .mask_wr (mask_wr)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    irqmux_channel #(
      .NUM_SRC (NUM_SRC)
    ) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .src     (src_lvl),
      .mask_we (mask_wr[c]),
      .wdata   (reg_wdata),
      .mask_q  (mask_all[c]),
      .pend    (pend_all[c]),
      .irq_q   (irq_out[c])
    );
  end

  irqmux_rdmux #(
    .NUM_CH  (NUM_CH),
    .NUM_SRC (NUM_SRC)
  ) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .kind     (kind),
    .ch_idx   (ch_idx),
    .mask_all (mask_all),
    .pend_all (pend_all),
    .rdata    (reg_rdata)
  );

  // R4: a write aimed at a pending register changes no mask
  assert_pend_write_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && kind == REG_PENDING) |=> $stable(mask_all));

  // R8: a write to an unmapped address changes no mask
  assert_unmapped_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && kind == REG_NONE) |=> $stable(mask_all));

endmodule

// File: tb/sim_irqmux_top.sv
module sim_irqmux_top;

  localparam int NSRC = 32;
  localparam int NCH  = 8;
  localparam int AW   = 12;

  logic            clk;
  logic            rst_n;
  logic [NSRC-1:0] src_lvl;
  logic [AW-1:0]   reg_addr;
  logic            reg_wr;
  logic [NSRC-1:0] reg_wdata;
  logic [NSRC-1:0] reg_rdata;
  logic [NCH-1:0]  irq_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  irqmux_top u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_lvl   (src_lvl),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_out   (irq_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;   // 200 MHz

  typedef struct packed {
    logic [2:0]  ch;
    logic [31:0] mask;
    logic [31:0] src;
  } vec_t;

  localparam vec_t VECS [0:7] = '{
    '{3'd0, 32'h0000_00FF, 32'h0000_0001},
    '{3'd1, 32'hFFFF_0000, 32'h0000_FFFF},
    '{3'd2, 32'h8000_0000, 32'h8000_0000},
    '{3'd3, 32'hA5A5_A5A5, 32'hFFFF_FFFF},
    '{3'd4, 32'h0000_0000, 32'hFFFF_FFFF},
    '{3'd5, 32'h1234_5678, 32'h0F0F_0F0F},
    '{3'd6, 32'hFFFF_FFFF, 32'h0000_0000},
    '{3'd7, 32'h0001_0000, 32'h0001_0000}
  };

  function automatic logic [AW-1:0] mask_addr(int ch);
    return AW'(32'h10 + 32'h40 * ch);
  endfunction

  function automatic logic [AW-1:0] pend_addr(int ch);
    return AW'(32'h20 + 32'h40 * ch);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge
  task automatic reg_write(logic [AW-1:0] a, logic [31:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic reg_read(logic [AW-1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] keep;
    rst_n     = 1'b0;
    src_lvl   = '0;
    reg_addr  = '0;
    reg_wr    = 1'b0;
    reg_wdata = '0;
    repeat (3) @(negedge clk);
    src_lvl = '1;
    rst_n   = 1'b1;
    @(negedge clk);

    // R1: reset state, sources already high but no mask set
    chk("R1 irq_out after reset", 32'(irq_out), 32'h0);
    for (int c = 0; c < NCH; c++) begin
      reg_read(mask_addr(c), rd);
      chk("R1 mask after reset", rd, 32'h0);
    end
    src_lvl = '0;

    // Table walk: R2 readback, R3 live pending, R5 output timing, R9
    for (int i = 0; i < 8; i++) begin
      vec_t v;
      logic [31:0] ep;
      v  = VECS[i];
      ep = v.src & v.mask;
      reg_write(mask_addr(int'(v.ch)), v.mask);
      src_lvl = v.src;
      reg_read(mask_addr(int'(v.ch)), rd);
      chk("R2 mask readback", rd, v.mask);
      reg_read(pend_addr(int'(v.ch)), rd);
      chk("R3 pending same cycle", rd, ep);
      chk("R5 irq before edge", 32'(irq_out), 32'h0);
      tick();
      chk("R5 irq one clock later", 32'(irq_out),
          (ep != 0) ? (32'h1 << v.ch) : 32'h0);
      src_lvl = '0;
      reg_write(mask_addr(int'(v.ch)), 32'h0);
      chk("R5 irq falls after source drops", 32'(irq_out), 32'h0);
    end

    // R3: pending follows the level in both directions without latching
    reg_write(mask_addr(2), 32'h0000_0F00);
    src_lvl = 32'h0000_0300;
    reg_read(pend_addr(2), rd);
    chk("R3 pending high level", rd, 32'h0000_0300);
    src_lvl = 32'h0000_0000;
    reg_read(pend_addr(2), rd);
    chk("R3 pending cleared by level", rd, 32'h0);

    // R4: writes to pending register ignored
    src_lvl = 32'h0000_0500;
    reg_write(pend_addr(2), 32'hFFFF_FFFF);
    reg_read(mask_addr(2), rd);
    chk("R4 mask after pending write", rd, 32'h0000_0F00);
    reg_read(pend_addr(2), rd);
    chk("R4 pending after pending write", rd, 32'h0000_0500);

    // R7: zero mask silences channel with all sources high
    src_lvl = '1;
    tick();
    chk("R7 irq on before clear", 32'(irq_out), 32'h0000_0004);
    reg_write(mask_addr(2), 32'h0);
    tick();
    chk("R7 irq silenced", 32'(irq_out), 32'h0);
    src_lvl = '0;

    // R6: neighbouring channels keep their masks
    reg_write(mask_addr(3), 32'hDEAD_BEEF);
    reg_write(mask_addr(4), 32'hCAFE_F00D);
    reg_write(mask_addr(3), 32'h0BAD_0001);
    reg_read(mask_addr(4), rd);
    chk("R6 neighbour mask kept", rd, 32'hCAFE_F00D);
    reg_read(mask_addr(3), rd);
    chk("R6 target mask updated", rd, 32'h0BAD_0001);
    reg_read(mask_addr(2), rd);
    chk("R6 lower neighbour untouched", rd, 32'h0);

    // R8: unmapped reads and writes
    reg_read(AW'(12'h000), rd);
    chk("R8 offset 0x00 read", rd, 32'h0);
    reg_read(AW'(12'h0F0), rd);
    chk("R8 offset 0x30 read", rd, 32'h0);
    reg_read(AW'(12'h0D2), rd);
    chk("R8 misaligned read", rd, 32'h0);
    reg_read(AW'(12'h210), rd);
    chk("R8 beyond last window read", rd, 32'h0);
    reg_write(AW'(12'h210), 32'h1111_1111);
    reg_write(AW'(12'h0D1), 32'h2222_2222);
    reg_write(AW'(12'h0C0), 32'h3333_3333);
    reg_read(mask_addr(0), rd);
    chk("R8 ch0 mask after unmapped writes", rd, 32'h0);
    reg_read(mask_addr(3), rd);
    chk("R8 ch3 mask after unmapped writes", rd, 32'h0BAD_0001);

    // R9: one source pattern, every channel with its own mask
    for (int c = 0; c < NCH; c++)
      reg_write(mask_addr(c), 32'h1 << (c * 4));
    src_lvl = 32'h0F0F_0F0F;
    for (int c = 0; c < NCH; c++) begin
      reg_read(pend_addr(c), rd);
      keep = 32'h0F0F_0F0F & (32'h1 << (c * 4));
      chk("R9 shared sources per channel", rd, keep);
    end
    tick();
    chk("R9 outputs of even channels", 32'(irq_out), 32'h0000_0055);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule